// File: doc/BRIEF.md
# Convolution Loop Sequencer

This block walks one convolution layer through its nested loops and emits, every working cycle, a feature-buffer read address and a weight-buffer read address for a bank of parallel multipliers. The layer shape arrives at run time: kernel size, input map width and height, stride, the number of input maps and the number of output maps. The number of multipliers, `NM`, is fixed when the block is built.

The sequencer picks how the multiplier bank is shared. If `NM` covers every input map, all input maps are handled in one pass, and the spare lanes take extra output maps. Each pass then covers `NM / nif` output maps, rounded down. If `NM` is smaller than the number of input maps, the input maps are split into groups of `NM`. The kernel window is swept once for each group before the scan moves on. This keeps exactly one partial sum open for each output position. A window-done flag tells the downstream accumulator when that sum is complete. A done pulse marks the end of the layer. A stall input freezes the whole walk.

Top module: `conv_loop_seq`

## Requirements
- R1: After reset, `busy`, `valid`, `win_done` and `done` are low.
- R2: A `start` pulse while idle captures all layer inputs, and `busy` and `valid` are high from the next cycle. A `start` while busy has no effect on the running sequence.
- R3: The loop nest, from fastest to slowest, is: kx over 0..k-1, ky over 0..k-1, input group, x position, y position, output group. The feature address is `(ig*yi + y*s + ky)*xi + x*s + kx`, where `ig` is the input group base.
- R4: The weight address is `((og*nif + ig)*k + ky)*k + kx`, where `og` is the output group base.
- R5: When `NM >= nif`, there is a single input group with base 0. Otherwise the group bases are 0, NM, 2·NM, … and every base is below `nif`.
- R6: The output group base steps by `NM / nif` (rounded down) when `NM >= nif`, and by 1 otherwise. Every base is below `nof`.
- R7: The x offsets are 0, s, 2s, …, and the last one satisfies offset + k ≤ xi. The y offsets follow the same rule against yi.
- R8: `win_done` is high exactly on valid cycles where kx = k-1, ky = k-1 and the input group is the last one.
- R9: While `stall` is high, `valid` is low and the counters hold, so both addresses keep their values.
- R10: `done` is high for one cycle, in the cycle after the last valid cycle, and `busy` is low from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a layer (accepted only while idle) |
| stall | input | 1 | Freeze the sequence |
| k | input | DW | Kernel size (≥1) |
| xi | input | DW | Input map width (≥k) |
| yi | input | DW | Input map height (≥k) |
| s | input | DW | Stride (≥1) |
| nif | input | DW | Number of input maps (≥1) |
| nof | input | DW | Number of output maps (≥1) |
| busy | output | 1 | Layer in progress |
| valid | output | 1 | Addresses are valid this cycle |
| feat_addr | output | AW | Feature buffer read address |
| wgt_addr | output | AW | Weight buffer read address |
| win_done | output | 1 | Accumulator may close the current sum |
| done | output | 1 | One-cycle end-of-layer pulse |

## Verification
The hardest case to reach is a stall on the very last step of a layer, just before the carries of every counter ripple into completion. A stall there must delay `done` and must not drop it. The bench drives a pseudo-random stall pattern through whole layers with several shapes, so stalls land at every loop boundary, including the final one. Two shapes sit on opposite sides of the `NM`-versus-`nif` split. A third puts the output count where the last output group is only partly filled. A behavioural loop model in the bench gives the expected address triple for every valid cycle.

// File: rtl/conv_loop_seq.sv
module conv_loop_seq #(
  parameter int NM = 4,
  parameter int DW = 8,
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stall,
  input  logic [DW-1:0] k,
  input  logic [DW-1:0] xi,
  input  logic [DW-1:0] yi,
  input  logic [DW-1:0] s,
  input  logic [DW-1:0] nif,
  input  logic [DW-1:0] nof,
  output logic          busy,
  output logic          valid,
  output logic [AW-1:0] feat_addr,
  output logic [AW-1:0] wgt_addr,
  output logic          win_done,
  output logic          done
);
  localparam logic [AW-1:0] NMA = AW'(NM);

  logic [DW-1:0] k_q, xi_q, yi_q, s_q, nif_q, nof_q, per_q, per_n;
  logic [DW-1:0] kx, ky, ig, xb, yb, og;
  logic kx_last, ky_last, ig_last, x_last, y_last, og_last, step;

  always_comb begin
    per_n = DW'(1);
    if (NM >= int'(nif))
      for (int p = 1; p <= NM; p++)
        if (p * int'(nif) <= NM) per_n = DW'(p);
  end

  assign kx_last = (kx == k_q - 1'b1);
  assign ky_last = (ky == k_q - 1'b1);
  assign ig_last = (AW'(ig) + NMA >= AW'(nif_q));
  assign x_last  = (AW'(xb) + AW'(s_q) + AW'(k_q) > AW'(xi_q));
  assign y_last  = (AW'(yb) + AW'(s_q) + AW'(k_q) > AW'(yi_q));
  assign og_last = (AW'(og) + AW'(per_q) >= AW'(nof_q));
  assign step    = busy && !stall;

  assign valid     = step;
  assign win_done  = step && kx_last && ky_last && ig_last;
  assign feat_addr = (AW'(ig) * AW'(yi_q) + AW'(yb) + AW'(ky)) * AW'(xi_q) + AW'(xb) + AW'(kx);
  assign wgt_addr  = ((AW'(og) * AW'(nif_q) + AW'(ig)) * AW'(k_q) + AW'(ky)) * AW'(k_q) + AW'(kx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0;
      k_q <= '0; xi_q <= '0; yi_q <= '0; s_q <= '0; nif_q <= '0; nof_q <= '0; per_q <= '0;
      kx <= '0; ky <= '0; ig <= '0; xb <= '0; yb <= '0; og <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          k_q <= k; xi_q <= xi; yi_q <= yi; s_q <= s; nif_q <= nif; nof_q <= nof;
          per_q <= per_n;
          kx <= '0; ky <= '0; ig <= '0; xb <= '0; yb <= '0; og <= '0;
        end
      end else if (step) begin
        kx <= kx_last ? '0 : kx + 1'b1;
        if (kx_last) begin
          ky <= ky_last ? '0 : ky + 1'b1;
          if (ky_last) begin
            ig <= ig_last ? '0 : ig + DW'(NM);
            if (ig_last) begin
              xb <= x_last ? '0 : xb + s_q;
              if (x_last) begin
                yb <= y_last ? '0 : yb + s_q;
                if (y_last) begin
                  if (og_last) begin
                    og <= '0; busy <= 1'b0; done <= 1'b1;
                  end else og <= og + per_q;
                end
              end
            end
          end
        end
      end
    end
  end
endmodule

module conv_loop_seq_chk #(parameter int AW = 24) (
  input logic clk, rst_n, stall, busy, valid, win_done, done,
  input logic [AW-1:0] feat_addr, wgt_addr
);
  p_idle_no_valid_r1: assert property (@(posedge clk) disable iff (!rst_n) valid |-> busy);
  p_wd_in_valid_r8:   assert property (@(posedge clk) disable iff (!rst_n) win_done |-> valid);
  p_stall_quiet_r9:   assert property (@(posedge clk) disable iff (!rst_n) stall |-> !valid);
  p_stall_hold_r9:    assert property (@(posedge clk) disable iff (!rst_n)
                        (stall && busy) |=> ($stable(feat_addr) && $stable(wgt_addr)));
  p_done_single_r10:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_done_idle_r10:    assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
endmodule

bind conv_loop_seq conv_loop_seq_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .stall(stall), .busy(busy), .valid(valid),
  .win_done(win_done), .done(done), .feat_addr(feat_addr), .wgt_addr(wgt_addr)
);

// File: tb/conv_loop_seq_tb.sv
module conv_loop_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 4, DW = 8, AW = 24;

  logic clk = 0, rst_n = 0, start = 0, stall = 0;
  logic [DW-1:0] k = 1, xi = 1, yi = 1, s = 1, nif = 1, nof = 1;
  logic busy, valid, win_done, done;
  logic [AW-1:0] feat_addr, wgt_addr;

  conv_loop_seq #(.NM(NM), .DW(DW), .AW(AW)) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  int qf[$], qw[$], qd[$];
  bit run_chk = 0, exp_done = 0, stall_en = 0, prev_stall = 0, done_seen = 0;
  logic [AW-1:0] prev_f, prev_w;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual %0d expected %0d", req, act, exp); end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    stall = stall_en && (lfsr[1:0] == 2'b00);
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && run_chk) begin
      if (prev_stall && busy) begin
        chk(feat_addr == prev_f, "R9 feat hold", int'(feat_addr), int'(prev_f));
        chk(wgt_addr == prev_w, "R9 wgt hold", int'(wgt_addr), int'(prev_w));
      end
      if (stall) chk(!valid, "R9 valid in stall", valid, 0);
      if (exp_done) begin
        chk(done, "R10 done pulse", done, 1);
        chk(!busy, "R10 busy after done", busy, 0);
        exp_done = 0; done_seen = 1;
      end else chk(!done, "R10 no stray done", done, 0);
      if (valid) begin
        if (qf.size() == 0) chk(0, "R10 valid after end", 1, 0);
        else begin
          int ef, ew, ed;
          ef = qf.pop_front(); ew = qw.pop_front(); ed = qd.pop_front();
          chk(int'(feat_addr) == ef, "R3 feat_addr", int'(feat_addr), ef);
          chk(int'(wgt_addr) == ew, "R4 wgt_addr", int'(wgt_addr), ew);
          chk(int'(win_done) == ed, "R8 win_done", win_done, ed);
          if (qf.size() == 0) exp_done = 1;
        end
      end
    end
    prev_stall = stall; prev_f = feat_addr; prev_w = wgt_addr;
  end

  task automatic build(int kk, int x, int y, int st, int ni, int no);
    int per, gstep;
    per = (NM >= ni) ? NM / ni : 1;
    gstep = (NM >= ni) ? ni : NM;
    for (int o = 0; o < no; o += per)
      for (int yy = 0; yy * st + kk <= y; yy++)
        for (int xx = 0; xx * st + kk <= x; xx++)
          for (int g = 0; g < ni; g += gstep)
            for (int b = 0; b < kk; b++)
              for (int a = 0; a < kk; a++) begin
                qf.push_back((g * y + yy * st + b) * x + xx * st + a);
                qw.push_back(((o * ni + g) * kk + b) * kk + a);
                qd.push_back((a == kk - 1 && b == kk - 1 && g + gstep >= ni) ? 1 : 0);
              end
  endtask

  task automatic run_case(int kk, int x, int y, int st, int ni, int no, bit stl, bit restart);
    build(kk, x, y, st, ni, no);
    @(posedge clk); #2;
    k = DW'(kk); xi = DW'(x); yi = DW'(y); s = DW'(st); nif = DW'(ni); nof = DW'(no);
    start = 1; stall_en = stl; done_seen = 0;
    @(posedge clk); #2; start = 0;
    chk(busy, "R2 busy after start", busy, 1);
    k = 1; xi = 9; yi = 9; nif = 1; nof = 1;
    if (restart) begin
      repeat (7) @(posedge clk);
      #2; start = 1; @(posedge clk); #2; start = 0;
    end
    while (!done_seen && cycles < 190000) @(posedge clk);
    chk(qf.size() == 0, "R3 all steps issued", qf.size(), 0);
    stall_en = 0;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(!busy && !valid && !done && !win_done, "R1 reset idle", {busy, valid, done, win_done}, 0);
    rst_n = 1;
    @(posedge clk); #2;
    chk(!busy && !valid, "R1 idle after reset", {busy, valid}, 0);
    run_chk = 1;
    run_case(3, 6, 5, 1, 2, 5, 0, 0);  // R6 per=2, partial last group
    run_case(2, 5, 5, 2, 10, 2, 0, 0); // R5 groups 0,4,8; R7 stride 2
    run_case(1, 3, 2, 1, 4, 3, 1, 0);  // R5 exact fit, R9 stalls
    run_case(2, 4, 3, 1, 3, 2, 1, 1);  // R6 per=1, R2 start ignored while busy
    run_case(3, 7, 5, 2, 6, 2, 1, 0);  // R7 offset limit, R8 with two groups
    run_chk = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles >= 195000);
    errors++; checks++;
    $display("FAIL watchdog actual %0d expected %0d", cycles, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule